// File: doc/BRIEF.md
# Black Level Servo

This block closes a per-line digital control loop around one channel of a video digitizer. It watches the 8-bit samples coming out of the converter. Once per line, after the horizontal sync pulse ends, it measures the black level during a quiet stretch of the line. It then nudges a 10-bit offset DAC code so that the measured black level settles on a chosen target code. A line's measurement waits a programmable number of pixels after the sync trailing edge. It then averages a power-of-two window of pixels, and those per-line averages are combined over a power-of-two number of lines before the code moves.

The sample stream passes through the block on a valid/ready interface. It has no storage, so it adds no latency. `out_valid` mirrors `in_valid` and `in_ready` mirrors `out_ready`. A pixel counts toward the schedule only in a cycle where both `in_valid` and `out_ready` are high, so downstream back-pressure stalls the schedule along with the data. Upstream must hold `in_data` steady while stalled. While the loop is running, a signed user offset is added to each sample, and the result is clamped to the 8-bit range. With the loop switched off, samples pass unchanged and the DAC code comes straight from a manual value.

The loop is controlled by an active-low enable, `loop_off`. It does not measure while the clock recovery loop reports coast, unless an override is set.

Top module: `black_level_servo`

## Requirements
- R1: After reset, with `loop_off` = 0, `dac_code` equals 512 (mid-scale).
- R2: A falling edge of `hsync` (high means sync active) starts a measurement. The first {`delay_hi`,`delay_lo`} accepted pixels after that edge are skipped. The measurement window begins with the next accepted pixel.
- R3: The measurement window spans 16 << `avg_sel` accepted pixels (sel 0 to 3 gives 16, 32, 64 or 128). The line's black value is their sum divided by that count, rounded down.
- R4: Line black values are summed over 1 << `line_sel` completed lines (1 to 128). Their mean, rounded down, is compared with `target_code` once at the end of each such group.
- R5: At the end of a line group, `dac_code` rises by 1 if the mean is below `target_code` and falls by 1 if it is above. If they are equal, it stays. It changes at no other time while the loop runs.
- R6: The servo code saturates at 0 and at 1023.
- R7: While `pll_coast` is 1 and `coast_meas_en` is 0, a sync falling edge starts no measurement. With `coast_meas_en` = 1, coast has no effect.
- R8: A sync falling edge that arrives during a measurement discards the partial measurement and restarts the skip count.
- R9: With `loop_off` = 1, `dac_code` equals `manual_code`, no measurement runs, `out_data` equals `in_data`, and the servo code is kept for when the loop is turned back on.
- R10: With `loop_off` = 0, `out_data` is `in_data` plus the two's-complement `user_offset`, clamped to 0..255.
- R11: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. Pixels offered while `out_ready` = 0 are not counted.
- R12: While the loop stays enabled, `dac_code` moves by at most 1 between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Upstream sample accepted |
| in_data | input | 8 | ADC sample |
| out_valid | output | 1 | Downstream sample valid |
| out_ready | input | 1 | Downstream can accept |
| out_data | output | 8 | Offset-corrected sample |
| hsync | input | 1 | Horizontal sync, high during the pulse |
| pll_coast | input | 1 | Clock recovery is coasting |
| coast_meas_en | input | 1 | 1 allows measurements during coast |
| loop_off | input | 1 | 1 disables the servo (active-low enable) |
| delay_hi | input | 8 | Upper byte of the skip count |
| delay_lo | input | 8 | Lower byte of the skip count |
| avg_sel | input | 2 | Pixel window select |
| line_sel | input | 3 | Line group select |
| target_code | input | 8 | Desired black level code |
| user_offset | input | 8 | Signed digital offset |
| manual_code | input | 10 | DAC code used when the loop is off |
| dac_code | output | 10 | Offset DAC code |

## Verification
The bench keeps every parameter at its default: an 8-bit sample path, a 10-bit DAC code, a 16-bit skip count and a 16-pixel minimum window. It programs a skip count of 3, so each line takes about thirty cycles. That short line makes it affordable to run the code all the way from mid-scale to 0 and then up to 1023, and to check that it holds at both ends. The window is bounded on each side by bright pixels, so an off-by-one in the skip or window count shows up as a wrong step direction.

// File: rtl/abls_pkg.sv
package abls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_AVG  = 2'd2
  } win_state_e;
endpackage

// File: rtl/abls_window.sv
module abls_window #(
  parameter int DATA_W       = 8,
  parameter int DLY_W        = 16,
  parameter int PIX_SEL_W    = 2,
  parameter int PIX_MIN_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync,
  input  logic                 pll_coast,
  input  logic                 coast_meas_en,
  input  logic                 loop_off,
  input  logic [DLY_W-1:0]     skip_cnt,
  input  logic [PIX_SEL_W-1:0] avg_sel,
  input  logic                 px_fire,
  input  logic [DATA_W-1:0]    px_data,
  output logic                 busy,
  output logic                 line_valid,
  output logic [DATA_W-1:0]    line_avg
);
  import abls_pkg::*;

  localparam int MAX_LOG2 = PIX_MIN_LOG2 + (1 << PIX_SEL_W) - 1;
  localparam int SUM_W    = DATA_W + MAX_LOG2;

  win_state_e        st;
  logic              hs_q;
  logic              trail;
  logic              allow;
  logic [DLY_W-1:0]  cnt;
  logic [DLY_W-1:0]  win_last;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  sum_nx;
  logic [31:0]       shift;

  always_comb begin
    trail    = hs_q & ~hsync;
    allow    = ~loop_off & (~pll_coast | coast_meas_en);
    shift    = 32'(PIX_MIN_LOG2) + 32'(avg_sel);
    win_last = DLY_W'((32'd1 << shift) - 32'd1);
    sum_nx   = sum + SUM_W'(px_data);
    busy     = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      hs_q       <= 1'b0;
      cnt        <= '0;
      sum        <= '0;
      line_valid <= 1'b0;
      line_avg   <= '0;
    end else begin
      hs_q       <= hsync;
      line_valid <= 1'b0;
      if (loop_off) begin
        st <= ST_IDLE;
      end else if (trail) begin
        cnt <= '0;
        sum <= '0;
        if (!allow)                st <= ST_IDLE;
        else if (skip_cnt == '0)   st <= ST_AVG;
        else                       st <= ST_SKIP;
      end else begin
        case (st)
          ST_SKIP: if (px_fire) begin
            if (cnt == skip_cnt - DLY_W'(1)) begin
              st  <= ST_AVG;
              cnt <= '0;
            end else begin
              cnt <= cnt + DLY_W'(1);
            end
          end
          ST_AVG: if (px_fire) begin
            sum <= sum_nx;
            if (cnt == win_last) begin
              line_avg   <= DATA_W'(sum_nx >> shift);
              line_valid <= 1'b1;
              st         <= ST_IDLE;
            end else begin
              cnt <= cnt + DLY_W'(1);
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/abls_lines.sv
module abls_lines #(
  parameter int DATA_W     = 8,
  parameter int LINE_SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [LINE_SEL_W-1:0] line_sel,
  input  logic                  line_valid,
  input  logic [DATA_W-1:0]     line_avg,
  input  logic [DATA_W-1:0]     target_code,
  output logic                  upd,
  output logic                  upd_up
);
  localparam int LCNT_W = (1 << LINE_SEL_W) - 1;
  localparam int ACC_W  = DATA_W + LCNT_W;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  acc_nx;
  logic [LCNT_W-1:0] lcnt;
  logic [LCNT_W-1:0] lcnt_last;
  logic [DATA_W-1:0] mean;

  always_comb begin
    acc_nx    = acc + ACC_W'(line_avg);
    lcnt_last = LCNT_W'((32'd1 << line_sel) - 32'd1);
    mean      = DATA_W'(acc_nx >> line_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      lcnt   <= '0;
      upd    <= 1'b0;
      upd_up <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (flush) begin
        acc  <= '0;
        lcnt <= '0;
      end else if (line_valid) begin
        if (lcnt == lcnt_last) begin
          upd    <= (mean != target_code);
          upd_up <= (mean < target_code);
          acc    <= '0;
          lcnt   <= '0;
        end else begin
          acc  <= acc_nx;
          lcnt <= lcnt + LCNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/abls_servo.sv
module abls_servo #(
  parameter int DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             upd_up,
  output logic [DAC_W-1:0] code
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);
  localparam logic [DAC_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= MID;
    end else if (upd) begin
      if (upd_up && code != TOP)        code <= code + DAC_W'(1);
      else if (!upd_up && code != '0)   code <= code - DAC_W'(1);
    end
  end
endmodule

// File: rtl/abls_offset.sv
module abls_offset #(
  parameter int DATA_W = 8
) (
  input  logic              bypass,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] user_offset,
  output logic [DATA_W-1:0] out_data
);
  localparam int SW = DATA_W + 2;

  logic signed [SW-1:0] a;
  logic signed [SW-1:0] b;
  logic signed [SW-1:0] s;
  logic signed [SW-1:0] top;

  always_comb begin
    a   = {2'b00, in_data};
    b   = {{2{user_offset[DATA_W-1]}}, user_offset};
    s   = a + b;
    top = {2'b00, {DATA_W{1'b1}}};
    if (bypass)          out_data = in_data;
    else if (s < 0)      out_data = '0;
    else if (s > top)    out_data = '1;
    else                 out_data = s[DATA_W-1:0];
  end
endmodule

// File: rtl/black_level_servo.sv
module black_level_servo #(
  parameter int DATA_W       = 8,
  parameter int DAC_W        = 10,
  parameter int DLY_BYTE_W   = 8,
  parameter int PIX_SEL_W    = 2,
  parameter int LINE_SEL_W   = 3,
  parameter int PIX_MIN_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_data,
  input  logic                  hsync,
  input  logic                  pll_coast,
  input  logic                  coast_meas_en,
  input  logic                  loop_off,
  input  logic [DLY_BYTE_W-1:0] delay_hi,
  input  logic [DLY_BYTE_W-1:0] delay_lo,
  input  logic [PIX_SEL_W-1:0]  avg_sel,
  input  logic [LINE_SEL_W-1:0] line_sel,
  input  logic [DATA_W-1:0]     target_code,
  input  logic [DATA_W-1:0]     user_offset,
  input  logic [DAC_W-1:0]      manual_code,
  output logic [DAC_W-1:0]      dac_code
);
  localparam int DLY_W = 2 * DLY_BYTE_W;

  logic              px_fire;
  logic              win_busy;
  logic              line_valid;
  logic [DATA_W-1:0] line_avg;
  logic              upd;
  logic              upd_up;
  logic [DAC_W-1:0]  servo_code;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign px_fire   = in_valid & out_ready;
  assign dac_code  = loop_off ? manual_code : servo_code;

  abls_window #(
    .DATA_W(DATA_W), .DLY_W(DLY_W),
    .PIX_SEL_W(PIX_SEL_W), .PIX_MIN_LOG2(PIX_MIN_LOG2)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .pll_coast(pll_coast),
    .coast_meas_en(coast_meas_en), .loop_off(loop_off),
    .skip_cnt({delay_hi, delay_lo}), .avg_sel(avg_sel),
    .px_fire(px_fire), .px_data(in_data),
    .busy(win_busy), .line_valid(line_valid), .line_avg(line_avg)
  );

  abls_lines #(.DATA_W(DATA_W), .LINE_SEL_W(LINE_SEL_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .flush(loop_off), .line_sel(line_sel),
    .line_valid(line_valid), .line_avg(line_avg), .target_code(target_code),
    .upd(upd), .upd_up(upd_up)
  );

  abls_servo #(.DAC_W(DAC_W)) u_servo (
    .clk(clk), .rst_n(rst_n), .upd(upd), .upd_up(upd_up), .code(servo_code)
  );

  abls_offset #(.DATA_W(DATA_W)) u_ofs (
    .bypass(loop_off), .in_data(in_data), .user_offset(user_offset),
    .out_data(out_data)
  );
endmodule

// File: rtl/abls_checker.sv
module abls_checker #(
  parameter int DAC_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync,
  input logic             pll_coast,
  input logic             coast_meas_en,
  input logic             loop_off,
  input logic [DAC_W-1:0] manual_code,
  input logic [DAC_W-1:0] dac_code,
  input logic             win_busy,
  input logic             line_valid,
  input logic             upd
);
  // R12: at most one step per cycle while the loop runs
  a_r12_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_off && $past(!loop_off)) |->
      (dac_code == $past(dac_code) || dac_code == $past(dac_code) + DAC_W'(1) ||
       dac_code == $past(dac_code) - DAC_W'(1)));

  // R5: the code only moves in the cycle after a group update
  a_r5_change_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_off && $past(!loop_off) && !$past(upd)) |-> $stable(dac_code));

  // R7: an edge during coast without override leaves the schedule idle
  a_r7_coast_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsync) && pll_coast && !coast_meas_en) |=> !win_busy);

  // R8: an edge never lets a partial window produce a result
  a_r8_edge_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |=> !line_valid);

  // R9: with the loop off the code follows only the manual value
  a_r9_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_off && $past(loop_off) && $stable(manual_code)) |-> $stable(dac_code));
endmodule

bind black_level_servo abls_checker #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .pll_coast(pll_coast),
  .coast_meas_en(coast_meas_en), .loop_off(loop_off),
  .manual_code(manual_code), .dac_code(dac_code),
  .win_busy(win_busy), .line_valid(line_valid), .upd(upd)
);

// File: tb/sim_black_level_servo.sv
module sim_black_level_servo;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       hsync = 1'b0;
  logic       pll_coast = 1'b0;
  logic       coast_meas_en = 1'b0;
  logic       loop_off = 1'b0;
  logic [7:0] delay_hi = 8'd0;
  logic [7:0] delay_lo = 8'd3;
  logic [1:0] avg_sel = 2'd0;
  logic [2:0] line_sel = 3'd0;
  logic [7:0] target_code = 8'd16;
  logic [7:0] user_offset = 8'd0;
  logic [9:0] manual_code = 10'h2A5;
  logic [9:0] dac_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_code = 512;

  always #(CLK_PERIOD/2) clk = ~clk;

  black_level_servo u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .hsync(hsync), .pll_coast(pll_coast),
    .coast_meas_en(coast_meas_en), .loop_off(loop_off),
    .delay_hi(delay_hi), .delay_lo(delay_lo), .avg_sel(avg_sel),
    .line_sel(line_sel), .target_code(target_code), .user_offset(user_offset),
    .manual_code(manual_code), .dac_code(dac_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic send_px(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    in_valid = 1'b0;
    hsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hsync = 1'b0;
  endtask

  // one line: bright skip pixels, black window, bright tail
  task automatic run_line(input logic [7:0] black, input bit stall);
    int n;
    n = 16 << avg_sel;
    sync_pulse();
    for (int i = 0; i < int'({delay_hi, delay_lo}); i++) send_px(8'd255);
    for (int i = 0; i < n; i++) begin
      if (stall && i == 5) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          in_valid  = 1'b1;
          in_data   = 8'd255;
          out_ready = 1'b0;
          #1 chk("R11 in_ready during stall", int'(in_ready), 0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        in_valid  = 1'b1;
        in_data   = black;
      end else begin
        send_px(black);
      end
    end
    send_px(8'd255);
    send_px(8'd255);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset code", int'(dac_code), 512);
    chk("R11 out_valid idle", int'(out_valid), 0);
    chk("R11 in_ready follows out_ready", int'(in_ready), 1);
  endtask

  task automatic t_step_down();
    for (int i = 0; i < 3; i++) begin
      run_line(8'd20, 1'b0);
      exp_code--;
      chk("R5 step down per line", int'(dac_code), exp_code);
    end
  endtask

  task automatic t_step_up();
    for (int i = 0; i < 2; i++) begin
      run_line(8'd10, 1'b0);
      exp_code++;
      chk("R5 step up per line", int'(dac_code), exp_code);
    end
  endtask

  task automatic t_window_edges();
    run_line(8'd16, 1'b0);
    chk("R2 R3 window bounded by skip count", int'(dac_code), exp_code);
    avg_sel = 2'd1;
    run_line(8'd16, 1'b0);
    chk("R3 32-pixel window exact", int'(dac_code), exp_code);
    delay_lo = 8'd0;
    run_line(8'd16, 1'b0);
    chk("R2 zero skip count", int'(dac_code), exp_code);
    delay_lo = 8'd3;
    avg_sel  = 2'd0;
  endtask

  task automatic t_line_group();
    line_sel = 3'd2;
    for (int i = 0; i < 3; i++) run_line(8'd20, 1'b0);
    chk("R4 no step before group ends", int'(dac_code), exp_code);
    run_line(8'd20, 1'b0);
    exp_code--;
    chk("R4 step after four lines", int'(dac_code), exp_code);
    line_sel = 3'd0;
  endtask

  task automatic t_coast();
    pll_coast = 1'b1;
    run_line(8'd20, 1'b0);
    chk("R7 coast blocks measurement", int'(dac_code), exp_code);
    coast_meas_en = 1'b1;
    run_line(8'd20, 1'b0);
    exp_code--;
    chk("R7 override measures in coast", int'(dac_code), exp_code);
    pll_coast = 1'b0;
    coast_meas_en = 1'b0;
  endtask

  task automatic t_abort();
    sync_pulse();
    for (int i = 0; i < 3; i++) send_px(8'd255);
    for (int i = 0; i < 8; i++) send_px(8'd100);
    run_line(8'd16, 1'b0);
    chk("R8 partial measurement discarded", int'(dac_code), exp_code);
  endtask

  task automatic t_stall();
    run_line(8'd20, 1'b1);
    exp_code--;
    chk("R11 stalled pixels not counted", int'(dac_code), exp_code);
  endtask

  task automatic t_disable();
    @(negedge clk);
    loop_off    = 1'b1;
    user_offset = 8'd10;
    in_valid    = 1'b1;
    in_data     = 8'd77;
    #1;
    chk("R9 manual code", int'(dac_code), 'h2A5);
    chk("R9 samples pass unchanged", int'(out_data), 77);
    chk("R11 out_valid follows in_valid", int'(out_valid), 1);
    run_line(8'd20, 1'b0);
    chk("R9 no measurement when off", int'(dac_code), 'h2A5);
    @(negedge clk);
    loop_off    = 1'b0;
    user_offset = 8'd0;
    #1 chk("R9 servo code kept", int'(dac_code), exp_code);
  endtask

  task automatic t_offset();
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 8'd250; user_offset = 8'd10;
    #1 chk("R10 clamp high", int'(out_data), 255);
    in_data = 8'd5; user_offset = 8'hEC;
    #1 chk("R10 clamp low", int'(out_data), 0);
    in_data = 8'd100; user_offset = 8'hFD;
    #1 chk("R10 signed add", int'(out_data), 97);
    in_data = 8'd100; user_offset = 8'd27;
    #1 chk("R10 positive add", int'(out_data), 127);
    @(negedge clk);
    in_valid = 1'b0;
    user_offset = 8'd0;
  endtask

  task automatic t_saturate();
    while (exp_code > 0) begin
      run_line(8'd20, 1'b0);
      exp_code--;
    end
    chk("R6 reached zero", int'(dac_code), 0);
    run_line(8'd20, 1'b0);
    run_line(8'd20, 1'b0);
    chk("R6 holds at zero", int'(dac_code), 0);
    while (exp_code < 1023) begin
      run_line(8'd10, 1'b0);
      exp_code++;
    end
    chk("R6 reached top", int'(dac_code), 1023);
    run_line(8'd10, 1'b0);
    run_line(8'd10, 1'b0);
    chk("R6 holds at top", int'(dac_code), 1023);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_step_down();
    t_step_up();
    t_window_edges();
    t_line_group();
    t_coast();
    t_abort();
    t_stall();
    t_disable();
    t_offset();
    t_saturate();
    finish_run();
  end
endmodule